// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a clocked model of the write-side command interface of a 16-bit NOR flash. Every cycle with the write enable high is one bus write. The block decodes the unlock-and-command sequences from those writes. It tracks the read mode, a bypass mode and a pending-operation state. It also drives a combinational read-data mux that selects between four sources: array data from an input port, identifier and protection words, the configuration register, and a busy status word.

When a single-word or two-word program sequence completes, the block raises a one-cycle start pulse towards an external program controller. The latched address and data go with the pulse. Reads then show busy status until the controller returns a done pulse. The array itself, voltage checks and erase are not modelled. Block protection bits arrive on an input vector.

Two unlock writes come before each command: AAh to 555h, then 55h to 2AAh. Only the low 11 address bits and the low data byte are compared when decoding unlock and command writes. Bypass mode drops the unlock writes. The configuration register is loaded from the address lines of a write, not from its data.

Top module: `flashCmdIf`

## Requirements
- R1: After reset, rdData equals arrayData, progStart, progDouble and errFlag are 0, and cfgPowerDown is 0 (all configuration bits clear).
- R2: After the unlock writes followed by 90h to 555h, reads select by rdAddr[1:0]. Value 00 returns 0x0020 (maker code). Value 01 returns 0x00A0 (device code).
- R3: In auto select, rdAddr[1:0]=10 returns 0x0001 if blockProt[rdAddr[18:12]] is set, and 0x0000 otherwise. rdAddr[1:0]=11 returns the 16-bit configuration register.
- R4: The sequence unlock, 60h to 555h, then a write whose data is 03h (any address) loads wrAddr[15:0] into the configuration register, and cfgPowerDown shows bit 10. Any other data in that last write leaves the register unchanged.
- R5: The sequence unlock, A0h to 555h, then one write pulses progStart for exactly the cycle after that write. In that cycle progAddr and progData0 hold the write's address and data, and progDouble is 0.
- R6: From the start pulse until the cycle after progDone, rdData is 0x0040 and every write is ignored. After that, reads return array data.
- R7: The sequence unlock, 40h to 555h, a first write, then a second write whose address matches the first in bits 18:1 starts a two-word program. progDouble is 1, progAddr is the first address, progData0 is the first data and progData1 is the second data.
- R8: If the second address of a two-word program differs from the first in any of bits 18:1, no start pulse occurs and errFlag becomes 1.
- R9: The sequence unlock then 20h to 555h enters bypass. In bypass, A0h at any address followed by one write starts a single program, and 40h at any address followed by two writes starts a two-word program. Bypass persists after each operation completes.
- R10: In bypass, 90h then 00h leaves bypass, after which A0h at a random address followed by a write starts nothing.
- R11: A wrong address or data in an unlock write ends the sequence, and a following command write starts nothing. Any write in auto select that does not re-enter it returns reads to array data.
- R12: F0h written to any address while idle, in an unlock step, or awaiting a configuration or bypass-exit confirm returns to read array. It also clears auto select, bypass and errFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One bus write per cycle high |
| wrAddr | input | 19 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 19 | Read address |
| rdData | output | 16 | Read data mux output |
| arrayData | input | 16 | Array word for rdAddr |
| blockProt | input | 128 | Protection bit per block |
| progDone | input | 1 | Program controller finished |
| progStart | output | 1 | One-cycle program start |
| progDouble | output | 1 | Start is a two-word program |
| progAddr | output | 19 | Program address |
| progData0 | output | 16 | First (or only) data word |
| progData1 | output | 16 | Second data word |
| errFlag | output | 1 | Two-word address mismatch seen |
| cfgPowerDown | output | 1 | Configuration power-down enable bit |

## Verification
A decoder stuck in the wrong state shows on the very next read. Auto select returns code words where array data was expected, a stuck busy state returns 0x0040, and a lost bypass flag makes the next bypass command start no pulse. Latch errors show up on progAddr and progData in the single cycle of the start pulse, so those fields are sampled in exactly that cycle. A configuration register loaded from the wrong source shows at once on cfgPowerDown and on the auto select read at offset 3.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLOCK1,
    ST_UNLOCK2,
    ST_PG_WAIT,
    ST_DW_FIRST,
    ST_DW_SECOND,
    ST_CR_WAIT,
    ST_XBY_WAIT,
    ST_BUSY
  } cmdState_e;

  typedef enum logic [1:0] {
    RD_ARRAY,
    RD_IDENT,
    RD_STATUS
  } rdSel_e;

  typedef struct packed {
    logic latchFirst;
    logic startSingle;
    logic startDouble;
    logic loadCfg;
    logic setErr;
    logic clearErr;
  } dpStrobe_t;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_DOUBLE  = 8'h40;
  localparam logic [7:0] CMD_CONFIG  = 8'h60;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_CFG_OK  = 8'h03;
  localparam logic [7:0] CMD_XBY_OK  = 8'h00;

  localparam int UNLOCK_AW = 11;
  localparam logic [UNLOCK_AW-1:0] UNLOCK_ADDR_A = 11'h555;
  localparam logic [UNLOCK_AW-1:0] UNLOCK_ADDR_B = 11'h2AA;

endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic [UNLOCK_AW-1:0] wrAddrLow,
  input  logic [7:0] wrDataLow,
  input  logic      progDone,
  input  logic      dwAddrMatch,
  output dpStrobe_t strb,
  output rdSel_e    rdSel
);

  cmdState_e state, stateNext;
  logic bypass, bypassNext;
  logic autoSel, autoSelNext;
  logic atAddrA, atAddrB, resetCmd, resetAllowed;

  assign atAddrA  = (wrAddrLow == UNLOCK_ADDR_A);
  assign atAddrB  = (wrAddrLow == UNLOCK_ADDR_B);
  assign resetCmd = (wrDataLow == CMD_RESET);
  assign resetAllowed = (state == ST_IDLE) || (state == ST_UNLOCK1) ||
                        (state == ST_UNLOCK2) || (state == ST_CR_WAIT) ||
                        (state == ST_XBY_WAIT);

  always_comb begin
    stateNext   = state;
    bypassNext  = bypass;
    autoSelNext = autoSel;
    strb        = '0;
    if (wrEn && resetAllowed && resetCmd) begin
      stateNext     = ST_IDLE;
      bypassNext    = 1'b0;
      autoSelNext   = 1'b0;
      strb.clearErr = 1'b1;
    end else if (wrEn) begin
      case (state)
        ST_IDLE: begin
          autoSelNext = 1'b0;
          if (bypass) begin
            case (wrDataLow)
              CMD_PROGRAM: stateNext = ST_PG_WAIT;
              CMD_DOUBLE:  stateNext = ST_DW_FIRST;
              CMD_IDENT:   stateNext = ST_XBY_WAIT;
              default:     stateNext = ST_IDLE;
            endcase
          end else if (atAddrA && wrDataLow == CMD_UNLOCK1) begin
            stateNext = ST_UNLOCK1;
          end
        end
        ST_UNLOCK1: begin
          if (atAddrB && wrDataLow == CMD_UNLOCK2) stateNext = ST_UNLOCK2;
          else                                     stateNext = ST_IDLE;
        end
        ST_UNLOCK2: begin
          stateNext = ST_IDLE;
          if (atAddrA) begin
            case (wrDataLow)
              CMD_IDENT:   autoSelNext = 1'b1;
              CMD_PROGRAM: stateNext   = ST_PG_WAIT;
              CMD_DOUBLE:  stateNext   = ST_DW_FIRST;
              CMD_CONFIG:  stateNext   = ST_CR_WAIT;
              CMD_BYPASS:  bypassNext  = 1'b1;
              default:     stateNext   = ST_IDLE;
            endcase
          end
        end
        ST_PG_WAIT: begin
          strb.startSingle = 1'b1;
          stateNext        = ST_BUSY;
        end
        ST_DW_FIRST: begin
          strb.latchFirst = 1'b1;
          stateNext       = ST_DW_SECOND;
        end
        ST_DW_SECOND: begin
          if (dwAddrMatch) begin
            strb.startDouble = 1'b1;
            stateNext        = ST_BUSY;
          end else begin
            strb.setErr = 1'b1;
            stateNext   = ST_IDLE;
          end
        end
        ST_CR_WAIT: begin
          if (wrDataLow == CMD_CFG_OK) strb.loadCfg = 1'b1;
          stateNext = ST_IDLE;
        end
        ST_XBY_WAIT: begin
          if (wrDataLow == CMD_XBY_OK) bypassNext = 1'b0;
          stateNext = ST_IDLE;
        end
        default: stateNext = state;
      endcase
    end
    if (state == ST_BUSY && progDone) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bypass  <= 1'b0;
      autoSel <= 1'b0;
    end else begin
      state   <= stateNext;
      bypass  <= bypassNext;
      autoSel <= autoSelNext;
    end
  end

  always_comb begin
    if (state == ST_BUSY) rdSel = RD_STATUS;
    else if (autoSel)     rdSel = RD_IDENT;
    else                  rdSel = RD_ARRAY;
  end

  AST_BUSY_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && wrEn) |=> $stable(bypass)); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchFirst, strb.startSingle, strb.startDouble,
              strb.loadCfg, strb.setErr, strb.clearErr})); // R8

  AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> !(strb.startSingle || strb.startDouble || strb.loadCfg)); // R6

endmodule

// File: rtl/flashCmdData.sv
module flashCmdData
  import flashCmdPkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int NUM_BLOCKS = 128,
  parameter logic [7:0] MAKER_CODE  = 8'h20,
  parameter logic [7:0] DEVICE_CODE = 8'hA0,
  parameter int BUSY_BIT   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [NUM_BLOCKS-1:0] blockProt,
  input  dpStrobe_t         strb,
  input  rdSel_e            rdSel,
  output logic              dwAddrMatch,
  output logic [DATA_W-1:0] rdData,
  output logic              progStart,
  output logic              progDouble,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData0,
  output logic [DATA_W-1:0] progData1,
  output logic              errFlag,
  output logic              cfgPowerDown
);

  localparam int BLK_W   = $clog2(NUM_BLOCKS);
  localparam int BLK_LSB = ADDR_W - BLK_W;
  localparam int CFG_W   = 16;
  localparam int PD_BIT  = 10;

  logic [CFG_W-1:0]  cfgReg;
  logic [ADDR_W-1:0] firstAddr;
  logic [DATA_W-1:0] firstData;
  logic [BLK_W-1:0]  blkSel;
  logic [DATA_W-1:0] identWord;
  logic [DATA_W-1:0] statusWord;

  assign dwAddrMatch = (wrAddr[ADDR_W-1:1] == firstAddr[ADDR_W-1:1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg     <= '0;
      firstAddr  <= '0;
      firstData  <= '0;
      progStart  <= 1'b0;
      progDouble <= 1'b0;
      progAddr   <= '0;
      progData0  <= '0;
      progData1  <= '0;
      errFlag    <= 1'b0;
    end else begin
      progStart <= strb.startSingle || strb.startDouble;
      if (strb.loadCfg) cfgReg <= wrAddr[CFG_W-1:0];
      if (strb.latchFirst) begin
        firstAddr <= wrAddr;
        firstData <= wrData;
      end
      if (strb.startSingle) begin
        progDouble <= 1'b0;
        progAddr   <= wrAddr;
        progData0  <= wrData;
        progData1  <= '0;
      end else if (strb.startDouble) begin
        progDouble <= 1'b1;
        progAddr   <= firstAddr;
        progData0  <= firstData;
        progData1  <= wrData;
      end
      if (strb.setErr)        errFlag <= 1'b1;
      else if (strb.clearErr) errFlag <= 1'b0;
    end
  end

  assign cfgPowerDown = cfgReg[PD_BIT];
  assign blkSel       = rdAddr[ADDR_W-1:BLK_LSB];

  always_comb begin
    identWord = '0;
    case (rdAddr[1:0])
      2'b00:   identWord[7:0] = MAKER_CODE;
      2'b01:   identWord[7:0] = DEVICE_CODE;
      2'b10:   identWord[0]   = blockProt[blkSel];
      default: identWord      = DATA_W'(cfgReg);
    endcase
  end

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_status
      assign statusWord[b] = (b == BUSY_BIT);
    end
  endgenerate

  always_comb begin
    case (rdSel)
      RD_STATUS: rdData = statusWord;
      RD_IDENT:  rdData = identWord;
      default:   rdData = arrayData;
    endcase
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCfg |=> $stable(cfgReg)); // R4

  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !progStart); // R8

  AST_START_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> ($stable(progAddr) || progStart)); // R5

endmodule

// File: rtl/flashCmdIf.sv
module flashCmdIf
  import flashCmdPkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int NUM_BLOCKS = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [NUM_BLOCKS-1:0] blockProt,
  input  logic              progDone,
  output logic              progStart,
  output logic              progDouble,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData0,
  output logic [DATA_W-1:0] progData1,
  output logic              errFlag,
  output logic              cfgPowerDown
);

  dpStrobe_t strb;
  rdSel_e    rdSel;
  logic      dwAddrMatch;

  flashCmdCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddrLow  (wrAddr[UNLOCK_AW-1:0]),
    .wrDataLow  (wrData[7:0]),
    .progDone   (progDone),
    .dwAddrMatch(dwAddrMatch),
    .strb       (strb),
    .rdSel      (rdSel)
  );

  flashCmdData #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BLOCKS(NUM_BLOCKS)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .arrayData   (arrayData),
    .blockProt   (blockProt),
    .strb        (strb),
    .rdSel       (rdSel),
    .dwAddrMatch (dwAddrMatch),
    .rdData      (rdData),
    .progStart   (progStart),
    .progDouble  (progDouble),
    .progAddr    (progAddr),
    .progData0   (progData0),
    .progData1   (progData1),
    .errFlag     (errFlag),
    .cfgPowerDown(cfgPowerDown)
  );

endmodule

// File: tb/flashCmdIf_tb.sv
module flashCmdIf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int NB = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [DW-1:0] arrayData;
  logic [NB-1:0] blockProt;
  logic progDone = 1'b0;
  logic progStart, progDouble, errFlag, cfgPowerDown;
  logic [AW-1:0] progAddr;
  logic [DW-1:0] progData0, progData1;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign arrayData = rdAddr[15:0] ^ 16'h5A5A;

  function automatic logic protBit(input int i);
    return ((i * 5 + 3) % 7) < 3;
  endfunction

  initial begin
    for (int i = 0; i < NB; i++) blockProt[i] = protBit(i);
  end

  flashCmdIf u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .arrayData(arrayData),
    .blockProt(blockProt), .progDone(progDone), .progStart(progStart),
    .progDouble(progDouble), .progAddr(progAddr), .progData0(progData0),
    .progData1(progData1), .errFlag(errFlag), .cfgPowerDown(cfgPowerDown)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    rdAddr = a;
    #1;
    chk(tag, {16'h0, rdData}, {16'h0, exp});
  endtask

  task automatic unlock();
    wr(19'h555, 16'h00AA);
    wr(19'h2AA, 16'h0055);
  endtask

  task automatic finishOp();
    @(negedge clk); progDone = 1'b1;
    @(negedge clk); progDone = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] a;
    logic [DW-1:0] d, d2, v, cfgNow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 rdData array", 19'h00123, 16'h0123 ^ 16'h5A5A);
    chk("R1 progStart", {31'h0, progStart}, 32'h0);
    chk("R1 errFlag", {31'h0, errFlag}, 32'h0);
    chk("R1 cfgPowerDown", {31'h0, cfgPowerDown}, 32'h0);
    chk("R1 progDouble", {31'h0, progDouble}, 32'h0);

    // R2 / R3 auto select
    unlock(); wr(19'h555, 16'h0090);
    rdChk("R2 maker", 19'h00000, 16'h0020);
    rdChk("R2 device", 19'h00001, 16'h00A0);
    for (int b = 0; b < NB; b++)
      rdChk("R3 protect", {7'(b), 10'h0, 2'b10}, {15'h0, protBit(b)});
    rdChk("R3 cfg reset", 19'h00003, 16'h0000);
    wr(19'h00000, 16'h00F0);
    rdChk("R12 F0 leaves ident", 19'h00000, 16'h5A5A);

    // R4 configuration sweep
    cfgNow = 16'h0;
    for (int i = 0; i < 6; i++) begin
      v = 16'(i * 16'h3A07 + 16'h0400 * (i % 2));
      unlock(); wr(19'h555, 16'h0060); wr({3'b101, v}, 16'h0003);
      cfgNow = v;
      chk("R4 cfgPowerDown", {31'h0, cfgPowerDown}, {31'h0, v[10]});
      unlock(); wr(19'h555, 16'h0090);
      rdChk("R3 cfg read", 19'h00003, v);
      wr(19'h0, 16'h00F0);
    end
    unlock(); wr(19'h555, 16'h0060); wr(19'h0FFFF, 16'h0004);
    unlock(); wr(19'h555, 16'h0090);
    rdChk("R4 bad confirm no load", 19'h00003, cfgNow);
    wr(19'h0, 16'h00F0);

    // R5 / R6 single program sweep
    for (int i = 0; i < 8; i++) begin
      a = 19'(i * 19'h1F3D + 5);
      d = 16'(i * 16'h1111) ^ 16'h00C3;
      unlock(); wr(19'h555, 16'h00A0); wr(a, d);
      chk("R5 start", {31'h0, progStart}, 32'h1);
      chk("R5 addr", {13'h0, progAddr}, {13'h0, a});
      chk("R5 data", {16'h0, progData0}, {16'h0, d});
      chk("R5 single", {31'h0, progDouble}, 32'h0);
      rdChk("R6 busy status", 19'h00000, 16'h0040);
      unlock();
      chk("R6 ignored no start", {31'h0, progStart}, 32'h0);
      wr(19'h555, 16'h0090);
      rdChk("R6 still busy", 19'h00001, 16'h0040);
      finishOp();
      rdChk("R6 back to array", 19'h00000, 16'h5A5A);
    end

    // R7 two-word program
    for (int i = 0; i < 4; i++) begin
      a = 19'(i * 19'h2461) & ~19'h1;
      a[0] = i[0];
      d = 16'(16'hBEEF + i); d2 = 16'(16'h1357 * (i + 1));
      unlock(); wr(19'h555, 16'h0040); wr(a, d);
      wr((i == 3) ? a : (a ^ 19'h1), d2);
      chk("R7 start", {31'h0, progStart}, 32'h1);
      chk("R7 double", {31'h0, progDouble}, 32'h1);
      chk("R7 addr", {13'h0, progAddr}, {13'h0, a});
      chk("R7 data0", {16'h0, progData0}, {16'h0, d});
      chk("R7 data1", {16'h0, progData1}, {16'h0, d2});
      finishOp();
    end

    // R8 mismatch in each upper bit
    for (int b = 1; b < AW; b++) begin
      a = 19'h12344;
      unlock(); wr(19'h555, 16'h0040); wr(a, 16'h1111);
      wr(a ^ (19'h1 << b), 16'h2222);
      chk("R8 no start", {31'h0, progStart}, 32'h0);
      chk("R8 errFlag", {31'h0, errFlag}, 32'h1);
      wr(19'h0, 16'h00F0);
      chk("R12 err cleared", {31'h0, errFlag}, 32'h0);
    end

    // R9 bypass
    unlock(); wr(19'h555, 16'h0020);
    for (int i = 0; i < 4; i++) begin
      a = 19'(19'h30000 + i * 19'h0777);
      wr(19'(i * 19'h123), 16'h00A0); wr(a, 16'(16'h0F0F + i));
      chk("R9 bypass single", {31'h0, progStart}, 32'h1);
      chk("R9 bypass data", {16'h0, progData0}, {16'h0, 16'(16'h0F0F + i)});
      finishOp();
      wr(19'(i * 19'h321), 16'h0040); wr(a, 16'h0A0A); wr(a ^ 19'h1, 16'h0B0B);
      chk("R9 bypass double", {31'h0, progStart & progDouble}, 32'h1);
      chk("R9 bypass data1", {16'h0, progData1}, 32'h0B0B);
      finishOp();
    end

    // R10 bypass exit
    wr(19'h01234, 16'h0090); wr(19'h04321, 16'h0000);
    wr(19'h01111, 16'h00A0); wr(19'h02222, 16'h0077);
    chk("R10 no start after exit", {31'h0, progStart}, 32'h0);
    rdChk("R10 array read", 19'h00010, 16'h0010 ^ 16'h5A5A);

    // R11 aborted sequences
    wr(19'h555, 16'h00AA); wr(19'h2AB, 16'h0055);
    wr(19'h555, 16'h00A0); wr(19'h00400, 16'h0077);
    chk("R11 bad addr no start", {31'h0, progStart}, 32'h0);
    wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0054); wr(19'h555, 16'h0090);
    rdChk("R11 bad data no ident", 19'h00000, 16'h5A5A);
    unlock(); wr(19'h555, 16'h0090);
    wr(19'h00123, 16'h0077);
    rdChk("R11 write exits ident", 19'h00000, 16'h5A5A);

    // R12 reset leaves bypass
    unlock(); wr(19'h555, 16'h0020); wr(19'h00000, 16'h00F0);
    wr(19'h00000, 16'h00A0); wr(19'h00500, 16'h0077);
    chk("R12 F0 exits bypass", {31'h0, progStart}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule